// File: doc/BRIEF.md
# Multi-Domain Clock Source Selection and Division

This block derives the clock enables for the CPU, USB, interval timer and capture timer domains of a small microcontroller, plus a selectable test clock output. Its three sources are an external clock input, a 24 MHz internal oscillator and a 32 kHz low-power oscillator. Each source arrives as a one-cycle tick that is synchronous to a fast system clock. Every domain has its own source selector and its own divider. Each domain produces a one-cycle enable pulse per divided period. The CPU, USB and interval timer domains also produce a level output that has 50% duty when the divisor is even.

Software programs four 4-bit setting fields through a write strobe, an address and write data. Reads return the most recently written values. A new source or divisor is held as pending. The domain adopts it only on the tick that ends its current divided period, so no output period is ever shortened. The interval timer can also run from the capture timer clock, which gives a cascaded timebase.

Top module: `clkctl_top`

## Requirements
- R1: After reset, addresses 0, 1, 2 and 3 read 0x01, 0x03, 0x01 and 0x0D. With no source ticks, no enable output pulses.
- R2: Address 0 holds bits [3:0], address 1 holds bits [1:0], address 2 holds bits [3:0] and address 3 holds bits [3:0]. The remaining bits of each address read as zero. A read returns the written value at once, before that value takes effect.
- R3: Address 0 bit 0 picks the CPU source: 0 selects the external input and 1 selects the 24 MHz oscillator. Ticks from the unselected source produce no cpu_en.
- R4: Address 0 bits [3:1] hold code c. For c from 0 to 5, cpu_en pulses once every 2^c source ticks. Codes 6 and 7 both divide by 128.
- R5: Address 1 bit 0 picks the USB source (0 external, 1 the 24 MHz oscillator). Bit 1 set divides by two. Bit 1 clear makes usb_en pulse on every source tick.
- R6: Address 2 bits [1:0] pick the interval timer source: 0 external, 1 the 24 MHz oscillator, 2 the 32 kHz oscillator, 3 the capture timer clock (cap_en).
- R7: Address 2 bits [3:2] hold value p. itmr_en then pulses once every p+1 ticks of its source, which covers divide-by-3.
- R8: Address 3 bits [1:0] pick the capture source: 0 external, 1 the 24 MHz oscillator, 2 or 3 the 32 kHz oscillator. cap_en pulses on every tick of the selected source.
- R9: Address 3 bits [3:2] pick the clkout_en source without delay: 0 external, 1 the 24 MHz oscillator, 2 the 32 kHz oscillator, 3 cpu_en.
- R10: A written source or divisor takes effect only after the domain's current period has ended. The pulse that closes that period still follows the old setting.
- R11: When the divisor D is even, cpu_clk, usb_clk and itmr_clk are high for the first D/2 source ticks of each period and low for the rest.
- R12: Reset clears every divider count, so the first enable pulse after reset comes on the D-th tick of the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | External clock tick |
| osc24_tick | input | 1 | 24 MHz oscillator tick |
| osc32_tick | input | 1 | 32 kHz oscillator tick |
| wr_en | input | 1 | Setting write strobe |
| addr | input | 2 | Setting address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| cpu_en | output | 1 | CPU clock enable pulse |
| cpu_clk | output | 1 | CPU divided level |
| usb_en | output | 1 | USB clock enable pulse |
| usb_clk | output | 1 | USB divided level |
| itmr_en | output | 1 | Interval timer enable pulse |
| itmr_clk | output | 1 | Interval timer divided level |
| cap_en | output | 1 | Capture timer enable pulse |
| clkout_en | output | 1 | Selected test clock output |

## Verification
The assertions check two things on every cycle. First, each divider count stays within its active limit and returns to zero after a pulse. Second, a domain's active source or limit changes only in the cycle after one of its own wrap pulses, so pending settings never cut a period short. They also check that every capture pulse coincides with some source tick, and that a written field appears in its setting register on the next cycle. The directed scenarios measure what no single-cycle property can show. They count the period of every domain, in ticks of its source, for every divider code. They count the high time of each level output, confirm the exact period that is in flight when a new divisor is written, and confirm that unselected sources are ignored.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int FIELD_W = 4;
    localparam int CPU_CW  = 7;
    localparam int USB_CW  = 1;
    localparam int ITMR_CW = 2;

    typedef enum logic [1:0] {
        OUT_EXT = 2'd0,
        OUT_O24 = 2'd1,
        OUT_O32 = 2'd2,
        OUT_CPU = 2'd3
    } out_sel_e;

    typedef struct packed {
        logic [2:0] div;
        logic       src;
    } cpu_cfg_t;

    typedef struct packed {
        logic half;
        logic src;
    } usb_cfg_t;

    typedef struct packed {
        logic [1:0] pre;
        logic [1:0] src;
    } itmr_cfg_t;

    typedef struct packed {
        out_sel_e   out;
        logic [1:0] cap;
    } misc_cfg_t;

    localparam cpu_cfg_t  CPU_RST  = '{div: 3'd0, src: 1'b1};
    localparam usb_cfg_t  USB_RST  = '{half: 1'b1, src: 1'b1};
    localparam itmr_cfg_t ITMR_RST = '{pre: 2'd0, src: 2'd1};
    localparam misc_cfg_t MISC_RST = '{out: OUT_CPU, cap: 2'd1};

    // Terminal count for the CPU divider: 2^n - 1, where codes 6 and 7 select n = 7
    function automatic logic [CPU_CW-1:0] cpu_limit(input logic [2:0] code);
        logic [CPU_CW:0] one_hot;
        logic [2:0]      n;
        n       = (code >= 3'd6) ? 3'd7 : code;
        one_hot = (CPU_CW+1)'(1) << n;
        return CPU_CW'(one_hot - (CPU_CW+1)'(1));
    endfunction

endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
    import clkctl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output cpu_cfg_t          cpu_o,
    output usb_cfg_t          usb_o,
    output itmr_cfg_t         itmr_o,
    output misc_cfg_t         misc_o
);

    cpu_cfg_t  cpu_q;
    usb_cfg_t  usb_q;
    itmr_cfg_t itmr_q;
    misc_cfg_t misc_q;
    logic      unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:FIELD_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_q  <= CPU_RST;
            usb_q  <= USB_RST;
            itmr_q <= ITMR_RST;
            misc_q <= MISC_RST;
        end else if (wr_en) begin
            case (addr)
                ADDR_W'(0): cpu_q  <= cpu_cfg_t'(wdata[3:0]);
                ADDR_W'(1): usb_q  <= usb_cfg_t'(wdata[1:0]);
                ADDR_W'(2): itmr_q <= itmr_cfg_t'(wdata[3:0]);
                ADDR_W'(3): misc_q <= misc_cfg_t'(wdata[3:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(0): rdata = DATA_W'(cpu_q);
            ADDR_W'(1): rdata = DATA_W'(usb_q);
            ADDR_W'(2): rdata = DATA_W'(itmr_q);
            ADDR_W'(3): rdata = DATA_W'(misc_q);
            default:    rdata = '0;
        endcase
    end

    assign cpu_o  = cpu_q;
    assign usb_o  = usb_q;
    assign itmr_o = itmr_q;
    assign misc_o = misc_q;

    // R2
    regs_cpu_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(0)) |=> (cpu_q == cpu_cfg_t'($past(wdata[3:0]))));

endmodule

// File: rtl/clkctl_div.sv
module clkctl_div #(
    parameter int             NSRC    = 2,
    parameter int             SW      = 1,
    parameter int             CW      = 1,
    parameter logic [SW-1:0]  RST_SEL = '0,
    parameter logic [CW-1:0]  RST_LIM = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  logic [SW-1:0]   sel_next,
    input  logic [CW-1:0]   lim_next,
    output logic            pulse_o,
    output logic            level_o
);

    logic [SW-1:0] sel_q;
    logic [CW-1:0] lim_q;
    logic [CW-1:0] cnt_q;
    logic [CW:0]   half;
    logic          tick;
    logic          wrap;

    assign tick = src_i[sel_q];
    assign wrap = tick && (cnt_q == lim_q);

    // Pending settings are adopted only when the running period closes
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= RST_SEL;
            lim_q <= RST_LIM;
            cnt_q <= '0;
        end else if (wrap) begin
            sel_q <= sel_next;
            lim_q <= lim_next;
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign half    = ({1'b0, lim_q} + (CW+1)'(1)) >> 1;
    assign pulse_o = wrap;
    assign level_o = ({1'b0, cnt_q} < half);

    // R12
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim_q);

    // R12
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> (cnt_q == '0));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lim_q != $past(lim_q) || sel_q != $past(sel_q)) |-> $past(pulse_o));

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
    import clkctl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_tick,
    input  logic              osc24_tick,
    input  logic              osc32_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              cpu_en,
    output logic              cpu_clk,
    output logic              usb_en,
    output logic              usb_clk,
    output logic              itmr_en,
    output logic              itmr_clk,
    output logic              cap_en,
    output logic              clkout_en
);

    cpu_cfg_t  cpu_cfg;
    usb_cfg_t  usb_cfg;
    itmr_cfg_t itmr_cfg;
    misc_cfg_t misc_cfg;
    logic      cap_lvl_unused;

    clkctl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .cpu_o  (cpu_cfg),
        .usb_o  (usb_cfg),
        .itmr_o (itmr_cfg),
        .misc_o (misc_cfg)
    );

    clkctl_div #(
        .NSRC(2), .SW(1), .CW(CPU_CW),
        .RST_SEL(CPU_RST.src), .RST_LIM(CPU_CW'(0))
    ) u_cpu (
        .clk      (clk),
        .rst      (rst),
        .src_i    ({osc24_tick, ext_tick}),
        .sel_next (cpu_cfg.src),
        .lim_next (cpu_limit(cpu_cfg.div)),
        .pulse_o  (cpu_en),
        .level_o  (cpu_clk)
    );

    clkctl_div #(
        .NSRC(2), .SW(1), .CW(USB_CW),
        .RST_SEL(USB_RST.src), .RST_LIM(USB_RST.half)
    ) u_usb (
        .clk      (clk),
        .rst      (rst),
        .src_i    ({osc24_tick, ext_tick}),
        .sel_next (usb_cfg.src),
        .lim_next (usb_cfg.half),
        .pulse_o  (usb_en),
        .level_o  (usb_clk)
    );

    clkctl_div #(
        .NSRC(4), .SW(2), .CW(1),
        .RST_SEL(MISC_RST.cap), .RST_LIM(1'b0)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .src_i    ({osc32_tick, osc32_tick, osc24_tick, ext_tick}),
        .sel_next (misc_cfg.cap),
        .lim_next (1'b0),
        .pulse_o  (cap_en),
        .level_o  (cap_lvl_unused)
    );

    clkctl_div #(
        .NSRC(4), .SW(2), .CW(ITMR_CW),
        .RST_SEL(ITMR_RST.src), .RST_LIM(ITMR_RST.pre)
    ) u_itmr (
        .clk      (clk),
        .rst      (rst),
        .src_i    ({cap_en, osc32_tick, osc24_tick, ext_tick}),
        .sel_next (itmr_cfg.src),
        .lim_next (itmr_cfg.pre),
        .pulse_o  (itmr_en),
        .level_o  (itmr_clk)
    );

    always_comb begin
        case (misc_cfg.out)
            OUT_EXT: clkout_en = ext_tick;
            OUT_O24: clkout_en = osc24_tick;
            OUT_O32: clkout_en = osc32_tick;
            default: clkout_en = cpu_en;
        endcase
    end

    // R8
    cap_src_chk: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> (ext_tick || osc24_tick || osc32_tick));

endmodule

// File: tb/clkctl_top_test.sv
module clkctl_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_tick = 1'b0;
    logic       osc24_tick = 1'b0;
    logic       osc32_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       cpu_en, cpu_clk, usb_en, usb_clk, itmr_en, itmr_clk, cap_en, clkout_en;
    logic [2:0] pre_lvl = 3'b000;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    clkctl_top uut (
        .clk(clk), .rst(rst),
        .ext_tick(ext_tick), .osc24_tick(osc24_tick), .osc32_tick(osc32_tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .cpu_en(cpu_en), .cpu_clk(cpu_clk), .usb_en(usb_en), .usb_clk(usb_clk),
        .itmr_en(itmr_en), .itmr_clk(itmr_clk), .cap_en(cap_en), .clkout_en(clkout_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of source ticks; outputs are valid on return (negedge)
    task automatic step(input bit e, input bit f, input bit s);
        @(posedge clk);
        #1;
        pre_lvl    = {itmr_clk, usb_clk, cpu_clk};
        ext_tick   = e;
        osc24_tick = f;
        osc32_tick = s;
        wr_en      = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk);
        #1;
        ext_tick = 0; osc24_tick = 0; osc32_tick = 0;
        wr_en = 1'b1; addr = 2'(a); wdata = 8'(d);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(posedge clk);
        #1;
        ext_tick = 0; osc24_tick = 0; osc32_tick = 0;
        addr = 2'(a);
        @(negedge clk);
        v = int'(rdata);
    endtask

    function automatic bit out_of(input int w);
        case (w)
            0: return cpu_en;
            1: return usb_en;
            2: return itmr_en;
            3: return cap_en;
            default: return clkout_en;
        endcase
    endfunction

    // Count ticks of source src until output w pulses; hi counts level-high ticks
    task automatic until_pulse(input int src, input int w, output int cnt, output int hi);
        bit found;
        found = 0;
        cnt = 0;
        hi = 0;
        for (int i = 0; i < 600 && !found; i++) begin
            step(src == 0, src == 1, src == 2);
            cnt++;
            if (w < 3 && pre_lvl[w]) hi++;
            if (out_of(w)) found = 1;
        end
        if (!found) cnt = 999;
    endtask

    task automatic measure(input int src, input int w, input int exp, input string req,
                           output int hi);
        int c;
        int h;
        until_pulse(src, w, c, h);
        until_pulse(src, w, c, hi);
        check(c == exp, req, c, exp);
    endtask

    task automatic t_reset;
        int v;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        rd(0, v); check(v == 8'h01, "R1 addr0 reset", v, 8'h01);
        rd(1, v); check(v == 8'h03, "R1 addr1 reset", v, 8'h03);
        rd(2, v); check(v == 8'h01, "R1 addr2 reset", v, 8'h01);
        rd(3, v); check(v == 8'h0D, "R1 addr3 reset", v, 8'h0D);
        step(0, 0, 0);
        v = {cpu_en, usb_en, itmr_en, cap_en, clkout_en};
        check(v == 0, "R1 no enables without ticks", v, 0);
        check(usb_clk == 1'b1, "R11 usb level high at count zero", usb_clk, 1);
        step(0, 1, 0);
        check(cpu_en == 1'b1, "R12 cpu first tick", cpu_en, 1);
        check(usb_en == 1'b0, "R12 usb not on first tick", usb_en, 0);
        step(0, 1, 0);
        check(usb_en == 1'b1, "R12 usb on second tick", usb_en, 1);
    endtask

    task automatic t_regs;
        int v;
        wr(0, 8'hFF); rd(0, v); check(v == 8'h0F, "R2 addr0 mask", v, 8'h0F);
        wr(1, 8'hFF); rd(1, v); check(v == 8'h03, "R2 addr1 mask", v, 8'h03);
        wr(2, 8'hA6); rd(2, v); check(v == 8'h06, "R2 addr2 mask", v, 8'h06);
        wr(3, 8'h5B); rd(3, v); check(v == 8'h0B, "R2 addr3 mask", v, 8'h0B);
        wr(0, 8'h01); wr(1, 8'h03); wr(2, 8'h01); wr(3, 8'h0D);
    endtask

    task automatic t_cpu;
        int h;
        int c;
        int bad;
        for (int code = 0; code < 8; code++) begin
            int exp;
            exp = (code >= 6) ? 128 : (1 << code);
            wr(0, (code << 1) | 1);
            measure(1, 0, exp, $sformatf("R4 cpu code %0d", code), h);
            if (code == 3) check(h == 4, "R11 cpu level high ticks", h, 4);
        end
        wr(0, 8'h00);
        until_pulse(1, 0, c, h);
        bad = 0;
        repeat (5) begin
            step(0, 1, 0);
            if (cpu_en) bad++;
        end
        check(bad == 0, "R3 osc24 ignored when external selected", bad, 0);
        step(1, 0, 0);
        check(cpu_en == 1'b1, "R3 external tick drives cpu", cpu_en, 1);
        wr(0, 8'h01);
        step(1, 0, 0);
    endtask

    task automatic t_shadow;
        int c;
        int h;
        int v;
        int bad;
        wr(0, 8'h07);
        until_pulse(1, 0, c, h);
        bad = 0;
        repeat (3) begin
            step(0, 1, 0);
            if (cpu_en) bad++;
        end
        check(bad == 0, "R10 no pulse mid period", bad, 0);
        wr(0, 8'h03);
        rd(0, v);
        check(v == 8'h03, "R2 read shows pending value", v, 8'h03);
        until_pulse(1, 0, c, h);
        check(c == 5, "R10 running period keeps old divisor", c, 5);
        until_pulse(1, 0, c, h);
        check(c == 2, "R10 new divisor after wrap", c, 2);
        wr(0, 8'h01);
        until_pulse(1, 0, c, h);
    endtask

    task automatic t_usb;
        int h;
        int bad;
        measure(1, 1, 2, "R5 usb half enabled", h);
        check(h == 1, "R11 usb level high ticks", h, 1);
        wr(1, 8'h01);
        measure(1, 1, 1, "R5 usb undivided", h);
        wr(1, 8'h00);
        step(0, 1, 0);
        bad = 0;
        repeat (3) begin
            step(0, 1, 0);
            if (usb_en) bad++;
        end
        check(bad == 0, "R5 osc24 ignored when external selected", bad, 0);
        step(1, 0, 0);
        check(usb_en == 1'b1, "R5 external tick drives usb", usb_en, 1);
        wr(1, 8'h03);
        step(1, 0, 0);
    endtask

    task automatic t_itmr;
        int h;
        int c;
        int bad;
        for (int p = 0; p < 4; p++) begin
            wr(2, (p << 2) | 1);
            measure(1, 2, p + 1, $sformatf("R7 prescale %0d", p + 1), h);
            if (p == 1) check(h == 1, "R11 itmr level /2", h, 1);
            if (p == 3) check(h == 2, "R11 itmr level /4", h, 2);
        end
        wr(2, 8'h01);
        until_pulse(1, 2, c, h);
        wr(3, 8'h0C);
        wr(2, 8'h0B);
        step(0, 1, 0);
        bad = 0;
        repeat (2) begin
            step(0, 1, 0);
            if (itmr_en) bad++;
        end
        check(bad == 0, "R6 capture source ignores osc24", bad, 0);
        measure(0, 2, 3, "R6 itmr from capture clock /3", h);
        wr(2, 8'h06);
        until_pulse(0, 2, c, h);
        measure(2, 2, 2, "R6 itmr from osc32 /2", h);
        wr(2, 8'h01);
        until_pulse(2, 2, c, h);
        wr(3, 8'h0D);
        step(1, 0, 0);
    endtask

    task automatic t_cap;
        for (int s = 0; s < 4; s++) begin
            int got;
            int exp;
            wr(3, 8'h0C | s);
            step(1, 1, 1);
            exp = (s == 0) ? 3'b001 : (s == 1) ? 3'b010 : 3'b100;
            step(1, 0, 0); got = int'(cap_en);
            step(0, 1, 0); got = got | (int'(cap_en) << 1);
            step(0, 0, 1); got = got | (int'(cap_en) << 2);
            check(got == exp, $sformatf("R8 capture source %0d", s), got, exp);
        end
        wr(3, 8'h0D);
        step(1, 1, 1);
    endtask

    task automatic t_clkout;
        int c;
        int h;
        for (int s = 0; s < 3; s++) begin
            int got;
            int exp;
            wr(3, (s << 2) | 1);
            exp = 1 << s;
            step(1, 0, 0); got = int'(clkout_en);
            step(0, 1, 0); got = got | (int'(clkout_en) << 1);
            step(0, 0, 1); got = got | (int'(clkout_en) << 2);
            check(got == exp, $sformatf("R9 clkout source %0d", s), got, exp);
        end
        wr(3, 8'h0D);
        wr(0, 8'h03);
        until_pulse(1, 0, c, h);
        until_pulse(1, 4, c, h);
        check(c == 2, "R9 clkout follows divided cpu", c, 2);
        wr(0, 8'h01);
        until_pulse(1, 0, c, h);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_cpu();
        t_shadow();
        t_usb();
        t_itmr();
        t_cap();
        t_clkout();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule